// File: doc/BRIEF.md
# Lane Configuration Serial Target

This block is the configuration port of a four-lane signal-conditioning device. It answers on a two-wire serial bus as an I2C target with a 7-bit address, for standard-mode (100 kbit/s) masters. It holds a small bank of 8-bit control registers and turns them into static per-lane control levels. Each lane has three controls: loopback, input disable and output disable. Loopback combined with the disables gives mux or demux routing. An active-low board strap forces loopback on every lane, whatever the registers hold.

The bus lines are sampled by a fast system clock. START and STOP are found as SDA edges while SCL is high. The device address mixes four fixed bits with three strap pins, so several devices can share one bus. Register access has no offset phase. Every transfer begins at register 0 and walks upward one register per byte, wrapping after the last one. Written bytes are held in a staging area and reach the live controls only when STOP is seen, which keeps multi-byte updates atomic. The controls are static setup. They are not meant to change glitch-free while traffic flows, so the lane pins are plain levels with no handshake.

Top module: `lane_cfg_i2c_target`

## Requirements
- R1: The target acknowledges only the address {1,1,A4,0,0,A1,A0}, where A4 = addr_strap_i[2], A1 = addr_strap_i[1] and A0 = addr_strap_i[0]. On any other address it leaves SDA released in the ninth clock and ignores the rest of the transfer.
- R2: The target pulls SDA low in the ninth clock after a matching address and after every byte the master writes.
- R3: On a read, bytes go out MSB first. A master ACK (SDA low in the ninth clock) makes the next register follow. After a master NACK the target leaves SDA released until the next START.
- R4: The register index is 0 at every START (repeated START included). It advances by one per data byte and wraps from 2 back to 0.
- R5: Written bytes change neither the lane outputs nor the read-back values until STOP. At STOP they are applied together.
- R6: lane_loop_o[n] is high when register 0 bit n is set or when loop_strap_n_i is low.
- R7: Register 0 bits 3:0 are the lane loopback bits. Its bits 7:4 are not stored and read as 0. Register 1 bits 3:0 drive lane_in_off_o and bits 7:4 drive lane_out_off_o.
- R8: Register 2 reads 8'hA5. A byte written to it is acknowledged and then discarded.
- R9: After reset all registers are zero, every lane output is low (with the strap high) and SDA is released.
- R10: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes written before a repeated START stay staged and are applied at the later STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | High pulls the open-drain SDA pad low |
| addr_strap_i | input | 3 | Address straps: [2]=A4, [1]=A1, [0]=A0 |
| loop_strap_n_i | input | 1 | Active-low strap forcing loopback on all lanes |
| lane_loop_o | output | 4 | Per-lane loopback select |
| lane_in_off_o | output | 4 | Per-lane input disable |
| lane_out_off_o | output | 4 | Per-lane output disable |

## Verification
Each bus line passes two synchronizer flops and one edge-detect flop. The target therefore acts on the third rising clock edge after an SCL or SDA change: ACK and read data appear on sda_drive_low_o three cycles after SCL falls, and the lane controls change three cycles after the SDA rise that forms STOP. The loopback strap reaches lane_loop_o in the same cycle, through logic only. The bench splits every bus bit into quarter phases of ten clocks, samples SDA in the middle of SCL high and reads the lane pins on falling clock edges a full quarter after STOP, so every result is sampled well after it settles.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  localparam int LANES    = 4;
  localparam int NUM_REGS = 3;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam logic [7:0] ID_BYTE = 8'hA5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_MACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_d, sda_d;

  // Idle bus is high, so reset to ones to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_q;
      sda_d    <= sda_q;
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign sda_s     = sda_q;
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import lcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_s,
  input  logic [6:0]       dev_addr_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_low_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  tgt_state_e       state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, txbyte;
  logic [PTR_W-1:0] ptr, ptr_nxt;
  logic             sda_low, rw, mack;

  assign ptr_nxt   = (ptr == PTR_W'(NUM_REGS-1)) ? '0 : ptr + 1'b1;
  assign sda_low_o = sda_low;
  assign ptr_o     = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txbyte    <= '0;
      ptr       <= '0;
      sda_low   <= 1'b0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bitcnt  <= '0;
        ptr     <= '0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == dev_addr_i) begin
                sda_low <= 1'b1;
                rw      <= shreg[0];
                state   <= ST_AACK;
              end else begin
                state   <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                txbyte  <= rd_data_i;
                sda_low <= ~rd_data_i[7];
                state   <= ST_RD;
              end else begin
                sda_low <= 1'b0;
                state   <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_low   <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_idx_o  <= ptr;
              wr_data_o <= shreg;
              ptr       <= ptr_nxt;
              state     <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              bitcnt  <= '0;
              state   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise && bitcnt < 4'd8) begin
              txbyte <= {txbyte[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_low <= 1'b0;
                ptr     <= ptr_nxt;
                state   <= ST_MACK;
              end else begin
                sda_low <= ~txbyte[7];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txbyte  <= rd_data_i;
                sda_low <= ~rd_data_i[7];
                bitcnt  <= '0;
                state   <= ST_RD;
              end else begin
                state   <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NUM_REGS);  // R4
  AST_START_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (ptr == '0));  // R4
  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && state == ST_AACK) |-> (shreg[7:1] == dev_addr_i));  // R1
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> sda_low);  // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_low);  // R3
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import lcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             commit_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [LANES-1:0] loop_bits_o,
  output logic [LANES-1:0] in_off_o,
  output logic [LANES-1:0] out_off_o
);
  localparam int CFG_W = 2 * LANES;

  logic [LANES-1:0] loop_r, stage_loop;
  logic [CFG_W-1:0] cfg_r, stage_cfg;
  logic             pend_loop, pend_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_r     <= '0;
      cfg_r      <= '0;
      stage_loop <= '0;
      stage_cfg  <= '0;
      pend_loop  <= 1'b0;
      pend_cfg   <= 1'b0;
    end else if (commit_i) begin
      if (pend_loop) loop_r <= stage_loop;
      if (pend_cfg)  cfg_r  <= stage_cfg;
      pend_loop <= 1'b0;
      pend_cfg  <= 1'b0;
    end else if (wr_en_i) begin
      // Index 2 (identity byte) falls through: write discarded.
      case (wr_idx_i)
        PTR_W'(0): begin
          stage_loop <= wr_data_i[LANES-1:0];
          pend_loop  <= 1'b1;
        end
        PTR_W'(1): begin
          stage_cfg <= wr_data_i[CFG_W-1:0];
          pend_cfg  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx_i)
      PTR_W'(0): rd_data_o = {{(8-LANES){1'b0}}, loop_r};
      PTR_W'(1): rd_data_o = cfg_r;
      PTR_W'(2): rd_data_o = ID_BYTE;
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign loop_bits_o = loop_r;
  assign in_off_o    = cfg_r[LANES-1:0];
  assign out_off_o   = cfg_r[CFG_W-1:LANES];

  AST_LOOP_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(loop_r) |-> $past(commit_i));  // R5
  AST_CFG_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_r) |-> $past(commit_i));  // R5
endmodule

// File: rtl/lane_cfg_i2c_target.sv
module lane_cfg_i2c_target
  import lcfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] ADDR_HI     = 2'b11,
  parameter logic [1:0] ADDR_MID    = 2'b00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_drive_low_o,
  input  logic [2:0]       addr_strap_i,
  input  logic             loop_strap_n_i,
  output logic [LANES-1:0] lane_loop_o,
  output logic [LANES-1:0] lane_in_off_o,
  output logic [LANES-1:0] lane_out_off_o
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]       dev_addr;
  logic [7:0]       rd_data, wr_data;
  logic [PTR_W-1:0] ptr, wr_idx;
  logic             wr_en;
  logic [LANES-1:0] loop_bits;

  assign dev_addr = {ADDR_HI, addr_strap_i[2], ADDR_MID, addr_strap_i[1:0]};

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_s      (sda_s),
    .dev_addr_i (dev_addr),
    .rd_data_i  (rd_data),
    .sda_low_o  (sda_drive_low_o),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  cfg_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .commit_i    (stop_det),
    .rd_idx_i    (ptr),
    .rd_data_o   (rd_data),
    .loop_bits_o (loop_bits),
    .in_off_o    (lane_in_off_o),
    .out_off_o   (lane_out_off_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_loop_o[g] = loop_bits[g] | ~loop_strap_n_i;
  end

  AST_STRAP_FORCES_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_strap_n_i |-> (&lane_loop_o));  // R6
endmodule

// File: tb/lane_cfg_i2c_target_test.sv
module lane_cfg_i2c_target_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic       loop_n = 1'b1;
  logic       sda_drive_low;
  logic [3:0] lane_loop, lane_in_off, lane_out_off;
  wire        sda_line = sda_m & ~sda_drive_low;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  lane_cfg_i2c_target uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_m),
    .sda_i           (sda_line),
    .sda_drive_low_o (sda_drive_low),
    .addr_strap_i    (strap),
    .loop_strap_n_i  (loop_n),
    .lane_loop_o     (lane_loop),
    .lane_in_off_o   (lane_in_off),
    .lane_out_off_o  (lane_out_off)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;    waitq();
    scl_m = 1'b1; waitq(); waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    b = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(ack ? 1'b0 : 1'b1);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {2'b11, s[2], 2'b00, s[1:0], rd};
  endfunction

  task automatic t_reset();
    chk("R9 loop after reset", lane_loop, 0);
    chk("R9 in_off after reset", lane_in_off, 0);
    chk("R9 out_off after reset", lane_out_off, 0);
    chk("R9 sda released after reset", sda_drive_low, 0);
  endtask

  task automatic t_addr_miss();
    bit a;
    bus_start();
    send_byte(addr_byte(3'b011, 1'b0), a);
    chk("R1 wrong address not acked", a, 0);
    send_byte(8'h0F, a);
    chk("R1 data after miss not acked", a, 0);
    bus_stop();
    chk("R1 miss leaves loop", lane_loop, 0);
  endtask

  task automatic t_write_commit();
    bit a;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), a);
    chk("R1 address ack", a, 1);
    send_byte(8'h05, a);
    chk("R2 byte0 ack", a, 1);
    send_byte(8'h3C, a);
    chk("R2 byte1 ack", a, 1);
    chk("R5 loop unchanged before stop", lane_loop, 0);
    chk("R5 in_off unchanged before stop", lane_in_off, 0);
    bus_stop();
    chk("R5 loop applied at stop", lane_loop, 4'h5);
    chk("R7 in_off bits 3:0", lane_in_off, 4'hC);
    chk("R7 out_off bits 7:4", lane_out_off, 4'h3);
  endtask

  task automatic t_strap();
    loop_n = 1'b0;
    @(negedge clk);
    chk("R6 strap forces all loopback", lane_loop, 4'hF);
    chk("R6 strap leaves in_off", lane_in_off, 4'hC);
    loop_n = 1'b1;
    @(negedge clk);
    chk("R6 strap released", lane_loop, 4'h5);
  endtask

  task automatic t_read_wrap();
    bit a;
    logic [7:0] d;
    logic b;
    bus_start();
    send_byte(addr_byte(strap, 1'b1), a);
    chk("R1 read address ack", a, 1);
    recv_byte(1'b1, d);
    chk("R3 read reg0", d, 8'h05);
    recv_byte(1'b1, d);
    chk("R3 read reg1", d, 8'h3C);
    recv_byte(1'b1, d);
    chk("R8 read id", d, 8'hA5);
    recv_byte(1'b0, d);
    chk("R4 read wraps to reg0", d, 8'h05);
    bit_in(b);
    chk("R3 released after nack", b, 1);
    bus_stop();
  endtask

  task automatic t_write_wrap();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), a);
    send_byte(8'h0A, a);
    send_byte(8'h81, a);
    send_byte(8'hFF, a);
    chk("R8 id write acked", a, 1);
    send_byte(8'hF3, a);
    chk("R4 wrapped write acked", a, 1);
    bus_stop();
    chk("R4 wrapped write lands in reg0", lane_loop, 4'h3);
    chk("R7 in_off", lane_in_off, 4'h1);
    chk("R7 out_off", lane_out_off, 4'h8);
    bus_start();
    send_byte(addr_byte(strap, 1'b1), a);
    recv_byte(1'b1, d);
    chk("R7 reg0 upper bits read zero", d, 8'h03);
    recv_byte(1'b1, d);
    chk("R7 reg1 readback", d, 8'h81);
    recv_byte(1'b0, d);
    chk("R8 id unchanged by write", d, 8'hA5);
    bus_stop();
  endtask

  task automatic t_repstart();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), a);
    send_byte(8'h06, a);
    bus_start();
    send_byte(addr_byte(strap, 1'b1), a);
    chk("R10 repeated start address ack", a, 1);
    recv_byte(1'b0, d);
    chk("R5 staged write not visible", d, 8'h03);
    chk("R5 loop unchanged at repeated start", lane_loop, 4'h3);
    bus_stop();
    chk("R10 staged write applied at stop", lane_loop, 4'h6);
  endtask

  task automatic t_strap_addr();
    bit a;
    strap = 3'b101;
    waitq();
    bus_start();
    send_byte(8'hC4, a);
    chk("R1 old address ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte(addr_byte(3'b101, 1'b0), a);
    chk("R1 new strap address acked", a, 1);
    send_byte(8'h0C, a);
    bus_stop();
    chk("R1 write under new address", lane_loop, 4'hC);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    waitq();
    t_reset();
    t_addr_miss();
    t_write_commit();
    t_strap();
    t_read_wrap();
    t_write_wrap();
    t_repstart();
    t_strap_addr();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule